// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This execution unit handles one family of instructions for a 32-bit processor. It takes an instruction word and the register values the register file has read for it. It forms the signed 64-bit product of two 32-bit operands. Depending on the instruction bits, it may fold in an accumulator that sits in the upper half of a 64-bit word, and it may round before truncating. It returns only the upper 32 bits of the result, together with the destination register index and a write enable.

The unit also exposes the three source register indices it decodes, so that the surrounding core can address its register file. It accepts work through a valid/ready pair and delivers results through another valid/ready pair. The pipeline has two register stages and a fixed two-cycle latency. When the consumer holds back, the pipeline stalls without losing or reordering operations. All intermediate arithmetic wraps modulo 2^64. No flags are produced.

Top module: `smmac_unit`

## Requirements
- R1: The unit decodes fields from `insn` as follows: destination index from bits 19:16 to `out_rd`, accumulator index from bits 15:12 to `src_a_idx`, second multiplicand index from bits 11:8 to `src_m_idx`, and first multiplicand index from bits 3:0 to `src_n_idx`. The three source indices are combinational.
- R2: When bits 15:12 equal 15, the result is bits 63:32 of the signed product `op_n * op_m`. In this case `op_a` and bit 6 have no effect.
- R3: When bits 15:12 are not 15 and bit 6 is 0, the 64-bit intermediate is `{op_a, 32'b0} + product`.
- R4: When bits 15:12 are not 15 and bit 6 is 1, the 64-bit intermediate is `{op_a, 32'b0} - product`. The operand order is fixed: the product is subtracted from the shifted accumulator, not the other way round.
- R5: When bit 5 is 1, the unit adds 0x80000000 to the 64-bit intermediate before taking bits 63:32, so a carry reaches the upper word.
- R6: All 64-bit arithmetic wraps modulo 2^64 without saturation. For example, 0x80000000 times 0x80000000 gives an upper word of 0x40000000.
- R7: With `out_ready` held high, a result appears on `out_valid` exactly two rising edges after the edge that accepts the input. The unit accepts one operation per cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values. Once both stages are full, `in_ready` goes to 0. Results leave the unit in the order they were accepted, and none are lost.
- R9: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R10: `out_we` is 1 exactly in cycles where `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can take an operation |
| insn | input | 32 | Instruction word |
| op_n | input | 32 | Value of the first multiplicand register |
| op_m | input | 32 | Value of the second multiplicand register |
| op_a | input | 32 | Value of the accumulator register |
| src_n_idx | output | 4 | First multiplicand register index |
| src_m_idx | output | 4 | Second multiplicand register index |
| src_a_idx | output | 4 | Accumulator register index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_rd | output | 4 | Destination register index |
| out_data | output | 32 | Upper word of the result |
| out_we | output | 1 | Register write enable |

## Verification
Two things can happen in the same cycle: a new operation can enter the first stage while a held result leaves the second. The bench provokes this by filling both stages while `out_ready` is low and keeping a third operation waiting at the input. It then raises `out_ready`. It checks that the drain, the advance and the acceptance all happen on one edge, and that the three results come out in order with their correct values. Rounding is also combined with the subtract mode in the same operation, and the bench checks it against the bench's 64-bit model.

// File: rtl/smmac_pkg.sv
package smmac_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned PROD_W   = 2 * XLEN;
    localparam int unsigned IDX_W    = 4;
    localparam int unsigned RD_LSB   = 16;
    localparam int unsigned RA_LSB   = 12;
    localparam int unsigned RM_LSB   = 8;
    localparam int unsigned RN_LSB   = 0;
    localparam int unsigned SUB_BIT  = 6;
    localparam int unsigned RND_BIT  = 5;
    localparam logic [IDX_W-1:0] NO_ACC_IDX = IDX_W'(15);
    localparam logic [PROD_W-1:0] ROUND_K  = PROD_W'(1) << (XLEN - 1);

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        acc_mode_e        mode;
        logic             rnd;
        logic [XLEN-1:0]  acc;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [PROD_W-1:0] prod;
    } stage1_t;

    function automatic ctrl_t decode_ctrl(input logic [XLEN-1:0] word,
                                          input logic [XLEN-1:0] acc_val);
        ctrl_t c;
        c.rd  = word[RD_LSB +: IDX_W];
        c.rnd = word[RND_BIT];
        c.acc = acc_val;
        if (word[RA_LSB +: IDX_W] == NO_ACC_IDX)
            c.mode = ACC_NONE;
        else if (word[SUB_BIT])
            c.mode = ACC_SUB;
        else
            c.mode = ACC_ADD;
        return c;
    endfunction

    function automatic logic [PROD_W-1:0] signed_product(input logic [XLEN-1:0] a,
                                                         input logic [XLEN-1:0] b);
        logic signed [PROD_W-1:0] ea;
        logic signed [PROD_W-1:0] eb;
        logic signed [PROD_W-1:0] p;
        ea = {{XLEN{a[XLEN-1]}}, a};
        eb = {{XLEN{b[XLEN-1]}}, b};
        p  = ea * eb;
        return p;
    endfunction

    function automatic logic [PROD_W-1:0] fold_acc(input acc_mode_e m,
                                                   input logic [XLEN-1:0] acc,
                                                   input logic [PROD_W-1:0] p,
                                                   input logic rnd);
        logic [PROD_W-1:0] hi;
        logic [PROD_W-1:0] r;
        hi = {acc, {XLEN{1'b0}}};
        case (m)
            ACC_ADD: r = hi + p;
            ACC_SUB: r = hi - p;
            default: r = p;
        endcase
        if (rnd)
            r = r + ROUND_K;
        return r;
    endfunction

endpackage

// File: rtl/smmac_decode.sv
module smmac_decode
    import smmac_pkg::*;
(
    input  logic [XLEN-1:0]  insn,
    input  logic [XLEN-1:0]  op_a,
    output logic [IDX_W-1:0] src_n_idx,
    output logic [IDX_W-1:0] src_m_idx,
    output logic [IDX_W-1:0] src_a_idx,
    output ctrl_t            ctrl
);
    logic unused_insn_bits;

    always_comb begin
        src_n_idx = insn[RN_LSB +: IDX_W];
        src_m_idx = insn[RM_LSB +: IDX_W];
        src_a_idx = insn[RA_LSB +: IDX_W];
        ctrl      = decode_ctrl(insn, op_a);
    end

    assign unused_insn_bits = ^{insn[XLEN-1:RD_LSB+IDX_W], insn[RM_LSB-1],
                                insn[RND_BIT-1:RN_LSB+IDX_W]};

    always_comb begin
        if (ctrl.mode == ACC_NONE)
            a_none_r2: assert (src_a_idx == NO_ACC_IDX);
    end
endmodule

// File: rtl/smmac_mul_stage.sv
module smmac_mul_stage
    import smmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  ctrl_t           ctrl_in,
    input  logic [XLEN-1:0] op_n,
    input  logic [XLEN-1:0] op_m,
    input  logic            next_take,
    output logic            s1_valid,
    output stage1_t         s1_data
);
    logic load;

    assign in_ready = !s1_valid || next_take;
    assign load     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_data  <= '0;
        end else begin
            if (load) begin
                s1_valid     <= 1'b1;
                s1_data.ctrl <= ctrl_in;
                s1_data.prod <= signed_product(op_n, op_m);
            end else if (next_take) begin
                s1_valid <= 1'b0;
            end
        end
    end

    p_no_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !next_take) |=> (s1_valid && $stable(s1_data)));
endmodule

// File: rtl/smmac_acc_stage.sv
module smmac_acc_stage
    import smmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s1_valid,
    input  stage1_t          s1_data,
    output logic             take,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_rd,
    output logic [XLEN-1:0]  out_data
);
    logic [PROD_W-1:0] folded;

    assign take   = s1_valid && (!out_valid || out_ready);
    assign folded = fold_acc(s1_data.ctrl.mode, s1_data.ctrl.acc,
                             s1_data.prod, s1_data.ctrl.rnd);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rd    <= '0;
            out_data  <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_rd    <= s1_data.ctrl.rd;
                out_data  <= folded[PROD_W-1:XLEN];
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_rd)));

    p_reset_empty_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    p_round_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (take && s1_data.ctrl.mode == ACC_NONE && s1_data.ctrl.rnd) |=>
        (out_data == $past(s1_data.prod[PROD_W-1:XLEN]) + XLEN'($past(s1_data.prod[XLEN-1]))));

    p_sub_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (take && s1_data.ctrl.mode == ACC_SUB && !s1_data.ctrl.rnd && s1_data.prod == '0) |=>
        (out_data == $past(s1_data.ctrl.acc)));
endmodule

// File: rtl/smmac_unit.sv
module smmac_unit
    import smmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] insn,
    input  logic [31:0] op_n,
    input  logic [31:0] op_m,
    input  logic [31:0] op_a,
    output logic [3:0]  src_n_idx,
    output logic [3:0]  src_m_idx,
    output logic [3:0]  src_a_idx,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [3:0]  out_rd,
    output logic [31:0] out_data,
    output logic        out_we
);
    ctrl_t   dec_ctrl;
    stage1_t s1_data;
    logic    s1_valid;
    logic    s2_take;

    smmac_decode u_dec (
        .insn      (insn),
        .op_a      (op_a),
        .src_n_idx (src_n_idx),
        .src_m_idx (src_m_idx),
        .src_a_idx (src_a_idx),
        .ctrl      (dec_ctrl)
    );

    smmac_mul_stage u_mul (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .ctrl_in   (dec_ctrl),
        .op_n      (op_n),
        .op_m      (op_m),
        .next_take (s2_take),
        .s1_valid  (s1_valid),
        .s1_data   (s1_data)
    );

    smmac_acc_stage u_acc (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_data   (s1_data),
        .take      (s2_take),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_rd    (out_rd),
        .out_data  (out_data)
    );

    assign out_we = out_valid && out_ready;

    p_two_stage_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(s1_valid));

    p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/smmac_unit_test.sv
module smmac_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] insn = '0;
    logic [31:0] op_n = '0;
    logic [31:0] op_m = '0;
    logic [31:0] op_a = '0;
    logic [3:0]  src_n_idx, src_m_idx, src_a_idx;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_rd;
    logic [31:0] out_data;
    logic        out_we;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    smmac_unit uut (.*);

    function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] n,
                                          input logic [31:0] m, input logic [31:0] a);
        logic signed [63:0] p;
        logic [63:0] r;
        p = $signed({{32{n[31]}}, n}) * $signed({{32{m[31]}}, m});
        r = p;
        if (w[15:12] != 4'd15) begin
            if (w[6]) r = {a, 32'b0} - r;
            else      r = {a, 32'b0} + r;
        end
        if (w[5]) r = r + 64'h8000_0000;
        return r[63:32];
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] rd, input logic [3:0] ra,
                                       input logic [3:0] rm, input logic [3:0] rn,
                                       input logic sub, input logic rnd);
        return {12'h0, rd, ra, rm, 1'b0, sub, rnd, 1'b1, rn};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [31:0] w, input logic [31:0] n,
                          input logic [31:0] m, input logic [31:0] a);
        logic [31:0] e;
        e = model(w, n, m, a);
        @(negedge clk);
        insn = w; op_n = n; op_m = m; op_a = a;
        in_valid = 1'b1; out_ready = 1'b1;
        #1;
        chk("R1 n idx", {28'b0, src_n_idx}, {28'b0, w[3:0]});
        chk("R1 m idx", {28'b0, src_m_idx}, {28'b0, w[11:8]});
        chk("R1 a idx", {28'b0, src_a_idx}, {28'b0, w[15:12]});
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 not after one edge", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R7 valid after two edges", {31'b0, out_valid}, 32'd1);
        chk("R10 write enable", {31'b0, out_we}, 32'd1);
        chk("R1 rd", {28'b0, out_rd}, {28'b0, w[19:16]});
        chk(req, out_data, e);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ea, eb, ec, wa, wb, wc;
        void'($urandom(32'h1bad_5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 out_valid after reset", {31'b0, out_valid}, 32'd0);
        chk("R9 in_ready after reset", {31'b0, in_ready}, 32'd1);

        run_op("R2 plain mul", mk(4'd3, 4'd15, 4'd2, 4'd1, 1'b0, 1'b0), 32'h0001_0000, 32'hFFFF_0000, 32'h0);
        chk("R2 value", out_data, 32'hFFFF_FFFF);
        run_op("R2 acc ignored", mk(4'd4, 4'd15, 4'd2, 4'd1, 1'b1, 1'b0), 32'h0001_0000, 32'hFFFF_0000, 32'h1234_5678);
        chk("R2 acc ignored value", out_data, 32'hFFFF_FFFF);
        run_op("R6 min x min", mk(4'd5, 4'd15, 4'd7, 4'd6, 1'b0, 1'b0), 32'h8000_0000, 32'h8000_0000, 32'h0);
        chk("R6 min x min value", out_data, 32'h4000_0000);
        run_op("R6 min x min round", mk(4'd5, 4'd15, 4'd7, 4'd6, 1'b0, 1'b1), 32'h8000_0000, 32'h8000_0000, 32'h0);
        chk("R6 min x min round value", out_data, 32'h4000_0000);
        run_op("R3 add", mk(4'd8, 4'd9, 4'd2, 4'd1, 1'b0, 1'b0), 32'h0000_0002, 32'h8000_0000, 32'h0000_0005);
        chk("R3 add value", out_data, 32'h0000_0004);
        run_op("R4 sub", mk(4'd9, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0), 32'h1, 32'h1, 32'h1);
        chk("R4 sub value", out_data, 32'h0);
        run_op("R4 sub order", mk(4'd9, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0), 32'h0001_0000, 32'h0003_0000, 32'h0000_0010);
        chk("R4 sub order value", out_data, 32'h0000_000D);
        run_op("R5 no round", mk(4'd1, 4'd15, 4'd2, 4'd3, 1'b0, 1'b0), 32'h1, 32'h8000_0000, 32'h0);
        chk("R5 no round value", out_data, 32'hFFFF_FFFF);
        run_op("R5 round carry", mk(4'd1, 4'd15, 4'd2, 4'd3, 1'b0, 1'b1), 32'h1, 32'h8000_0000, 32'h0);
        chk("R5 round carry value", out_data, 32'h0);
        run_op("R5 R4 round with sub", mk(4'd2, 4'd0, 4'd2, 4'd3, 1'b1, 1'b1), 32'h1, 32'h8000_0000, 32'h7);
        chk("R5 R4 round with sub value", out_data, 32'h0000_0008);
        run_op("R6 wrap add", mk(4'd2, 4'd0, 4'd2, 4'd3, 1'b0, 1'b1), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = $urandom();
            if (i % 4 == 0) w[15:12] = 4'd15;
            run_op("R3 R4 R5 random", w, $urandom(), $urandom(), $urandom());
        end

        wa = mk(4'd10, 4'd15, 4'd1, 4'd2, 1'b0, 1'b0);
        wb = mk(4'd11, 4'd3, 4'd1, 4'd2, 1'b1, 1'b1);
        wc = mk(4'd12, 4'd4, 4'd1, 4'd2, 1'b0, 1'b0);
        ea = model(wa, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0);
        eb = model(wb, 32'h8000_0000, 32'h7FFF_FFFF, 32'h5555_5555);
        ec = model(wc, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hAAAA_0001);
        @(negedge clk);
        out_ready = 1'b0;
        insn = wa; op_n = 32'h1234_5678; op_m = 32'h9ABC_DEF0; op_a = 32'h0; in_valid = 1'b1;
        @(negedge clk);
        insn = wb; op_n = 32'h8000_0000; op_m = 32'h7FFF_FFFF; op_a = 32'h5555_5555;
        @(negedge clk);
        insn = wc; op_n = 32'hFFFF_FFFF; op_m = 32'hFFFF_FFFF; op_a = 32'hAAAA_0001;
        #1;
        chk("R8 in_ready low when full", {31'b0, in_ready}, 32'd0);
        chk("R10 no write when stalled", {31'b0, out_we}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R8 held valid", {31'b0, out_valid}, 32'd1);
        chk("R8 held data", out_data, ea);
        chk("R8 held rd", {28'b0, out_rd}, 32'd10);
        out_ready = 1'b1;
        #1;
        chk("R8 ready while draining", {31'b0, in_ready}, 32'd1);
        chk("R10 write on handshake", {31'b0, out_we}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second in order", out_data, eb);
        chk("R8 second rd", {28'b0, out_rd}, 32'd11);
        @(negedge clk);
        chk("R8 third in order", out_data, ec);
        chk("R8 third rd", {28'b0, out_rd}, 32'd12);
        @(negedge clk);
        chk("R7 empty after drain", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule